// File: doc/BRIEF.md
# Gated Timer with Compare Reset

A synchronous up-counter advanced by a prescaled one-cycle tick. Counting can be qualified by an external gate pin whose active level is programmable. The pin is brought into the clock domain through a short flop chain before it qualifies counting.

A compare register sits beside the counter. In the special-event mode (mode code 4'b1011), a tick that finds the counter equal to the compare value reloads zero instead of incrementing. The compare register then acts as a period register, and the block can fire a one-cycle start pulse toward an external converter. In every other mode, a compare hit only raises a sticky match flag.

A normal roll-over past the all-ones value raises a sticky overflow flag. A clear caused by a compare hit never raises it. Software loads the counter, the compare register and the control fields through write strobes. A counter write always takes priority over whatever the tick would have done in that cycle.

Top module: `gtmr_cmp_timer`

## Requirements
- R1: Reset state: count 0, compare 0, mode 0, run 0, gate enable 0, gate polarity 0. Both flags are 0, conv_start is 0 and the gate synchronizer is 0.
- R2: The counter advances by one on a clock edge only when run is 1, tick is 1 and the gate permits counting. Otherwise it holds its value, unless it is written.
- R3: With gate enable 1 and polarity 0, the gate permits counting while the synchronized gate is 0 and blocks it while the gate is 1.
- R4: With gate enable 1 and polarity 1, the gate permits counting while the synchronized gate is 1 and blocks it while the gate is 0.
- R5: With gate enable 0, the gate pin has no effect on counting.
- R6: The gate pin passes through SYNC_STAGES flops. The pin level present before edge k governs the counting decision at edge k+SYNC_STAGES.
- R7: In mode 4'b1011, a counting edge that finds count equal to compare loads 0. The counter cycles 0 to compare, a period of compare+1 counting edges.
- R8: A special-event clear never sets ovf_flag. This includes a compare value of all ones.
- R9: A counter write (wr_cnt_en) loads wr_cnt_data on that edge. It overrides both the increment and the special-event clear.
- R10: conv_start is high for the one cycle after a counting edge that produced a special-event hit. It does so only if conv_en was 1 at that edge. It stays low in every other case.
- R11: A counting edge that advances count from all ones to zero sets ovf_flag. A counter write on that edge suppresses this. The flag is sticky. flag_clr clears ovf_flag and match_flag, but a set on the same edge wins.
- R12: In a mode other than 4'b1011, a counting edge at count equal to compare sets match_flag. The counter still increments, and conv_start stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cnt_en | input | 1 | Counter write strobe |
| wr_cnt_data | input | W | Counter write value |
| wr_cmp_en | input | 1 | Compare register write strobe |
| wr_cmp_data | input | W | Compare write value |
| wr_ctl_en | input | 1 | Control write strobe |
| wr_ctl_mode | input | 4 | Compare mode code (4'b1011 = special event) |
| wr_ctl_run | input | 1 | Timer run enable |
| wr_ctl_gate_en | input | 1 | Gate qualification enable |
| wr_ctl_gate_pol | input | 1 | Gate active level |
| flag_clr | input | 1 | Clears ovf_flag and match_flag |
| tick | input | 1 | Prescaled count tick |
| gate_pin | input | 1 | Asynchronous gate input |
| conv_en | input | 1 | Converter enable, qualifies conv_start |
| count | output | W | Current counter value |
| ovf_flag | output | 1 | Sticky roll-over flag |
| match_flag | output | 1 | Sticky compare-hit flag (non-special modes) |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The bench builds the block with its defaults: W of 16 and SYNC_STAGES of 2. With 16 bits, loading counter values a few steps below 16'hFFFF makes roll-over, and a compare value of all ones, reachable in a handful of ticks. The two-stage chain gives a gate latency short enough that randomly toggling pins exercise both stages in a few cycles. Compare values are kept mostly below 16, so special-event periods repeat many times in each run.

// File: rtl/gtmr_cmp_timer.sv
module gtmr_cmp_timer #(
  parameter int W = 16,
  parameter int MW = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [MW-1:0] SPECIAL_MODE = 4'b1011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt_en,
  input  logic [W-1:0]  wr_cnt_data,
  input  logic          wr_cmp_en,
  input  logic [W-1:0]  wr_cmp_data,
  input  logic          wr_ctl_en,
  input  logic [MW-1:0] wr_ctl_mode,
  input  logic          wr_ctl_run,
  input  logic          wr_ctl_gate_en,
  input  logic          wr_ctl_gate_pol,
  input  logic          flag_clr,
  input  logic          tick,
  input  logic          gate_pin,
  input  logic          conv_en,
  output logic [W-1:0]  count,
  output logic          ovf_flag,
  output logic          match_flag,
  output logic          conv_start
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0]          count_q, cmp_q;
  logic [MW-1:0]         mode_q;
  logic                  run_q, gate_en_q, gate_pol_q;
  logic [SYNC_STAGES-1:0] gsync_q;
  logic                  ovf_q, match_q, conv_q;

  wire gate_s   = gsync_q[SYNC_STAGES-1];
  wire gate_ok  = !gate_en_q || (gate_s == gate_pol_q);
  wire inc      = run_q && tick && gate_ok;
  wire special  = (mode_q == SPECIAL_MODE);
  wire hit      = inc && (count_q == cmp_q);
  wire sp_clear = hit && special;
  wire rollover = inc && (count_q == ALL_ONES) && !sp_clear && !wr_cnt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gsync_q <= '0;
    end else begin
      gsync_q <= {gsync_q[SYNC_STAGES-2:0], gate_pin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_cnt_en) begin
      count_q <= wr_cnt_data;
    end else if (sp_clear) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q      <= '0;
      mode_q     <= '0;
      run_q      <= 1'b0;
      gate_en_q  <= 1'b0;
      gate_pol_q <= 1'b0;
    end else begin
      if (wr_cmp_en) cmp_q <= wr_cmp_data;
      if (wr_ctl_en) begin
        mode_q     <= wr_ctl_mode;
        run_q      <= wr_ctl_run;
        gate_en_q  <= wr_ctl_gate_en;
        gate_pol_q <= wr_ctl_gate_pol;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      conv_q <= sp_clear && conv_en;
      if (rollover)      ovf_q <= 1'b1;
      else if (flag_clr) ovf_q <= 1'b0;
      if (hit && !special) match_q <= 1'b1;
      else if (flag_clr)   match_q <= 1'b0;
    end
  end

  assign count      = count_q;
  assign ovf_flag   = ovf_q;
  assign match_flag = match_q;
  assign conv_start = conv_q;

endmodule

// File: rtl/gtmr_cmp_timer_chk.sv
module gtmr_cmp_timer_chk #(
  parameter int W = 16,
  parameter int MW = 4,
  parameter logic [MW-1:0] SPECIAL_MODE = 4'b1011
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_cnt_en,
  input logic [W-1:0]  wr_cnt_data,
  input logic          conv_en,
  input logic [W-1:0]  count,
  input logic          ovf_flag,
  input logic          conv_start,
  input logic [W-1:0]  cmp_q,
  input logic [MW-1:0] mode_q,
  input logic          inc
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_cnt_en) |=> $stable(count));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_en |=> (count == $past(wr_cnt_data)));

  p_period_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_cnt_en && mode_q == SPECIAL_MODE && count == cmp_q) |=> (count == '0));

  p_match_counts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_cnt_en && mode_q != SPECIAL_MODE) |=> (count == $past(count) + 1'b1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(inc && !wr_cnt_en && count == {W{1'b1}} &&
                              !(mode_q == SPECIAL_MODE && count == cmp_q)));

  p_conv_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(conv_en && inc && mode_q == SPECIAL_MODE && count == cmp_q));

endmodule

bind gtmr_cmp_timer gtmr_cmp_timer_chk #(.W(W), .MW(MW), .SPECIAL_MODE(SPECIAL_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cnt_en(wr_cnt_en), .wr_cnt_data(wr_cnt_data),
  .conv_en(conv_en), .count(count), .ovf_flag(ovf_flag), .conv_start(conv_start),
  .cmp_q(cmp_q), .mode_q(mode_q), .inc(inc)
);

// File: tb/gtmr_cmp_timer_tb_top.sv
module gtmr_cmp_timer_tb_top;
  localparam int W = 16;
  localparam logic [3:0] SP = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_cnt_en = 0, wr_cmp_en = 0, wr_ctl_en = 0;
  logic [W-1:0] wr_cnt_data = '0, wr_cmp_data = '0;
  logic [3:0] wr_ctl_mode = '0;
  logic wr_ctl_run = 0, wr_ctl_gate_en = 0, wr_ctl_gate_pol = 0;
  logic flag_clr = 0, tick = 0, gate_pin = 0, conv_en = 0;
  logic [W-1:0] count;
  logic ovf_flag, match_flag, conv_start;

  always #10 clk = ~clk;

  gtmr_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_cnt_en(wr_cnt_en), .wr_cnt_data(wr_cnt_data),
    .wr_cmp_en(wr_cmp_en), .wr_cmp_data(wr_cmp_data), .wr_ctl_en(wr_ctl_en),
    .wr_ctl_mode(wr_ctl_mode), .wr_ctl_run(wr_ctl_run), .wr_ctl_gate_en(wr_ctl_gate_en),
    .wr_ctl_gate_pol(wr_ctl_gate_pol), .flag_clr(flag_clr), .tick(tick),
    .gate_pin(gate_pin), .conv_en(conv_en), .count(count), .ovf_flag(ovf_flag),
    .match_flag(match_flag), .conv_start(conv_start));

  // reference model state
  logic [W-1:0] m_cnt, m_cmp;
  logic [3:0] m_mode;
  logic m_run, m_ge, m_gp, m_s0, m_s1, m_ovf, m_mf, m_cs;
  int vectors = 0, errors = 0;
  string cur_tag = "R1";

  function automatic logic gate_permits(logic ge, logic gp, logic g);
    return !ge || (g == gp);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_mode = '0; m_run = 0; m_ge = 0; m_gp = 0;
      m_s0 = 0; m_s1 = 0; m_ovf = 0; m_mf = 0; m_cs = 0;
    end else begin
      logic inc_e, hit_e, sp_e;
      sp_e  = (m_mode == SP);
      inc_e = m_run && tick && gate_permits(m_ge, m_gp, m_s1);
      hit_e = inc_e && (m_cnt == m_cmp);
      m_cs  = hit_e && sp_e && conv_en;
      if (inc_e && m_cnt == '1 && !(hit_e && sp_e) && !wr_cnt_en) m_ovf = 1;
      else if (flag_clr) m_ovf = 0;
      if (hit_e && !sp_e) m_mf = 1;
      else if (flag_clr) m_mf = 0;
      if (wr_cnt_en) m_cnt = wr_cnt_data;
      else if (hit_e && sp_e) m_cnt = '0;
      else if (inc_e) m_cnt = m_cnt + 1'b1;
      if (wr_cmp_en) m_cmp = wr_cmp_data;
      if (wr_ctl_en) begin
        m_mode = wr_ctl_mode; m_run = wr_ctl_run; m_ge = wr_ctl_gate_en; m_gp = wr_ctl_gate_pol;
      end
      m_s1 = m_s0; m_s0 = gate_pin;
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    chk("count", count, m_cnt);
    chk("ovf_flag", W'(ovf_flag), W'(m_ovf));
    chk("match_flag", W'(match_flag), W'(m_mf));
    chk("conv_start", W'(conv_start), W'(m_cs));
    wr_cnt_en = 0; wr_cmp_en = 0; wr_ctl_en = 0; flag_clr = 0;
  endtask

  task automatic ctl(logic [3:0] md, logic run, logic ge, logic gp);
    wr_ctl_en = 1; wr_ctl_mode = md; wr_ctl_run = run; wr_ctl_gate_en = ge; wr_ctl_gate_pol = gp;
    cyc();
  endtask

  task automatic ld_cnt(logic [W-1:0] v);
    wr_cnt_en = 1; wr_cnt_data = v; cyc();
  endtask

  task automatic ld_cmp(logic [W-1:0] v);
    wr_cmp_en = 1; wr_cmp_data = v; cyc();
  endtask

  task automatic run_rand_gate(int n);
    for (int i = 0; i < n; i++) begin
      gate_pin = 1'($urandom);
      tick = ($urandom % 4) != 0;
      cyc();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    cur_tag = "R1";
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    cur_tag = "R2/R5";
    ld_cmp(16'h0100);
    ctl(4'b0000, 1, 0, 0);
    run_rand_gate(40);

    cur_tag = "R3/R6";
    ctl(4'b0000, 1, 1, 0);
    run_rand_gate(40);

    cur_tag = "R4/R6";
    ctl(4'b0000, 1, 1, 1);
    run_rand_gate(40);

    cur_tag = "R7/R10";
    ctl(SP, 1, 0, 0);
    ld_cmp(16'd5); ld_cnt('0);
    conv_en = 1; tick = 1;
    repeat (30) cyc();
    cur_tag = "R10";
    conv_en = 0;
    repeat (15) cyc();

    cur_tag = "R8";
    conv_en = 1;
    ld_cmp('1); ld_cnt(16'hFFFC);
    repeat (10) cyc();

    cur_tag = "R9";
    ld_cmp(16'd3); ld_cnt(16'd3);
    wr_cnt_en = 1; wr_cnt_data = 16'd9; cyc();
    repeat (4) cyc();

    cur_tag = "R11";
    ctl(4'b0000, 1, 0, 0);
    ld_cnt(16'hFFFD);
    repeat (5) cyc();
    flag_clr = 1; cyc();
    ld_cnt(16'hFFFF);
    flag_clr = 1; cyc();
    wr_cnt_en = 1; wr_cnt_data = 16'hFFFF; cyc();
    wr_cnt_en = 1; wr_cnt_data = 16'h0010; cyc();

    cur_tag = "R12";
    ctl(4'b0010, 1, 0, 0);
    ld_cmp(16'd4); ld_cnt('0);
    repeat (8) cyc();
    flag_clr = 1; cyc();
    repeat (4) cyc();

    cur_tag = "R2/R7/R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      tick = ($urandom % 3) != 0;
      gate_pin = ($urandom % 5) == 0 ? ~gate_pin : gate_pin;
      conv_en = ($urandom % 4) != 0;
      flag_clr = ($urandom % 40) == 0;
      if (r < 4) begin
        wr_cnt_en = 1;
        wr_cnt_data = ($urandom % 2) ? W'(16'hFFF0 + $urandom % 16) : W'($urandom % 16);
      end else if (r < 6) begin
        wr_cmp_en = 1;
        wr_cmp_data = ($urandom % 8) == 0 ? '1 : W'($urandom % 16);
      end else if (r < 8) begin
        wr_ctl_en = 1;
        wr_ctl_mode = ($urandom % 2) ? SP : 4'($urandom);
        wr_ctl_run = ($urandom % 6) != 0;
        wr_ctl_gate_en = 1'($urandom);
        wr_ctl_gate_pol = 1'($urandom);
      end
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule